// File: doc/BRIEF.md
# SHA-256 Two-Round Compression Step

This block advances a SHA-256 working state by two rounds per operation. The eight working words arrive split over two 128-bit operands. The first operand carries a, b, e and f. The second carries c, d, g and h. A third operand supplies two message words, and the caller has already added the round constants to them.

After the two chained rounds, the block returns only the new a, b, e and f, packed into one 128-bit word. Because the state shifts down by two places each step, the caller can rebuild the new c, d, g and h from the operands it already holds. Constant storage, message expansion, padding and the final feed-forward all stay with the caller.

A one-cycle `start` pulse captures the operands. The packed result appears in a register on the next cycle, and `valid` is high for that one cycle.

Top module: `sha2r_core`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `valid` is 0 and `result` is all zeros.
- R2: `valid` is 1 in exactly the cycle after each cycle in which `start` is 1, and 0 otherwise.
- R3: Each round computes t1 = h + S1(e) + Ch(e,f,g) + w and t2 = S0(a) + Maj(a,b,c). The state then shifts so that a gets t1+t2 and e gets d+t1; b, c and d take the old a, b and c; f, g and h take the old e, f and g. S0 is the XOR of e... rotate-rights of its input by 2, 13 and 22. S1 is the XOR of rotate-rights by 6, 11 and 25. Ch = (e&f)^(~e&g) and Maj = (a&b)^(a&c)^(b&c).
- R4: Input lane order is as follows. `opAbef` holds a in bits 31:0, b in 63:32, e in 95:64 and f in 127:96. `opCdgh` holds c, d, g and h in the same lanes. `result` holds the final a, b, e and f in bits 31:0, 63:32, 95:64 and 127:96.
- R5: The first round uses the word in `opMsg[31:0]` and the second round uses the word in `opMsg[63:32]`. Bits 127:64 of `opMsg` have no effect on `result`.
- R6: In a cycle where `start` is 0, `result` keeps its value whatever the operand inputs do.
- R7: Every addition wraps modulo 2^32.
- R8: When `start` is high on consecutive cycles, each operation's result appears in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture the operands and compute two rounds |
| opAbef | input | 128 | Working words a, b, e, f |
| opCdgh | input | 128 | Working words c, d, g, h |
| opMsg | input | 128 | Two message-plus-constant words in the low 64 bits |
| valid | output | 1 | Result is fresh this cycle |
| result | output | 128 | Final a, b, e, f after two rounds |

## Verification
Both rounds are evaluated between the operand inputs and the result register. Each result is therefore due exactly one clock edge after the edge that samples `start`, and `valid` rises on that same edge. The bench drives its inputs on the falling edge and samples on the following falling edge, which lands inside the single cycle in which `valid` is high. In back-to-back runs, the bench checks one result on each falling edge, in step with the starts it issued. The hold and ignored-bit checks sample `result` after the changed inputs have had at least one full clock edge to disturb it.

// File: rtl/sha2r_pkg.sv
package sha2r_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = 4;
  localparam int BUS_W  = WORD_W * LANES;
  localparam int ROUNDS = 2;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a, b, c, d, e, f, g, h;
  } state_t;

  typedef struct packed {
    logic capture;
    logic validSet;
  } ctrlStrobe_t;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t bigSigma0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t bigSigma1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t chooseFn(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t majorityFn(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

  function automatic state_t roundStep(input state_t s, input word_t w);
    state_t n;
    word_t  t1;
    word_t  t2;
    t1  = s.h + bigSigma1(s.e) + chooseFn(s.e, s.f, s.g) + w;
    t2  = bigSigma0(s.a) + majorityFn(s.a, s.b, s.c);
    n.h = s.g;
    n.g = s.f;
    n.f = s.e;
    n.e = s.d + t1;
    n.d = s.c;
    n.c = s.b;
    n.b = s.a;
    n.a = t1 + t2;
    return n;
  endfunction
endpackage

// File: rtl/sha2r_ctrl.sv
module sha2r_ctrl
  import sha2r_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output ctrlStrobe_t strobe,
  output logic        valid
);
  always_comb begin
    strobe.capture  = start;
    strobe.validSet = start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= strobe.validSet;
  end
endmodule

// File: rtl/sha2r_dp.sv
module sha2r_dp
  import sha2r_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  logic [BUS_W-1:0] opAbef,
  input  logic [BUS_W-1:0] opCdgh,
  input  logic [BUS_W-1:0] opMsg,
  output logic [BUS_W-1:0] result
);
  state_t stage [ROUNDS+1];

  always_comb begin
    stage[0].a = opAbef[0*WORD_W +: WORD_W];
    stage[0].b = opAbef[1*WORD_W +: WORD_W];
    stage[0].e = opAbef[2*WORD_W +: WORD_W];
    stage[0].f = opAbef[3*WORD_W +: WORD_W];
    stage[0].c = opCdgh[0*WORD_W +: WORD_W];
    stage[0].d = opCdgh[1*WORD_W +: WORD_W];
    stage[0].g = opCdgh[2*WORD_W +: WORD_W];
    stage[0].h = opCdgh[3*WORD_W +: WORD_W];
  end

  for (genvar r = 0; r < ROUNDS; r++) begin : g_round
    assign stage[r+1] = roundStep(stage[r], opMsg[r*WORD_W +: WORD_W]);
  end

  logic [BUS_W-1:0] packedNext;
  always_comb begin
    packedNext = {stage[ROUNDS].f, stage[ROUNDS].e, stage[ROUNDS].b, stage[ROUNDS].a};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              result <= '0;
    else if (strobe.capture) result <= packedNext;
  end
endmodule

// File: rtl/sha2r_core.sv
module sha2r_core
  import sha2r_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BUS_W-1:0] opAbef,
  input  logic [BUS_W-1:0] opCdgh,
  input  logic [BUS_W-1:0] opMsg,
  output logic             valid,
  output logic [BUS_W-1:0] result
);
  ctrlStrobe_t strobe;

  sha2r_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .strobe (strobe),
    .valid  (valid)
  );

  sha2r_dp u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .opAbef (opAbef),
    .opCdgh (opCdgh),
    .opMsg  (opMsg),
    .result (result)
  );
endmodule

// File: rtl/sha2r_chk.sv
module sha2r_chk
  import sha2r_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             valid,
  input logic [BUS_W-1:0] result
);
  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !valid); // R2
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !start |=> $stable(result)); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> (!valid && result == '0)); // R1
endmodule

bind sha2r_core sha2r_chk u_chk (.*);

// File: tb/sha2r_core_tb.sv
module sha2r_core_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] opAbef = '0;
  logic [127:0] opCdgh = '0;
  logic [127:0] opMsg = '0;
  logic         valid;
  logic [127:0] result;

  int checks = 0;
  int fails = 0;
  logic [31:0] seed = 32'h1234_5679;

  sha2r_core u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return {x, x} >> n;
  endfunction

  function automatic logic [127:0] model(input logic [127:0] ab, input logic [127:0] cd,
                                          input logic [127:0] m);
    logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
    a = ab[31:0]; b = ab[63:32]; e = ab[95:64]; f = ab[127:96];
    c = cd[31:0]; d = cd[63:32]; g = cd[95:64]; h = cd[127:96];
    for (int i = 0; i < 2; i++) begin
      t1 = h + (rr(e,6) ^ rr(e,11) ^ rr(e,25)) + ((e & f) ^ (~e & g)) + m[i*32 +: 32];
      t2 = (rr(a,2) ^ rr(a,13) ^ rr(a,22)) + ((a & b) ^ (a & c) ^ (b & c));
      h = g; g = f; f = e; e = d + t1; d = c; c = b; b = a; a = t1 + t2;
    end
    return {f, e, b, a};
  endfunction

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic randWide(output logic [127:0] v);
    for (int k = 0; k < 4; k++) begin
      seed = nextRand(seed);
      v[k*32 +: 32] = seed;
    end
  endtask

  task automatic runOp(input string req, input logic [127:0] ab, input logic [127:0] cd,
                       input logic [127:0] m);
    @(negedge clk);
    opAbef = ab; opCdgh = cd; opMsg = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " R2 valid"}, {127'd0, valid}, 128'd1);
    check(req, result, model(ab, cd, m));
  endtask

  initial begin
    logic [127:0] ab, cd, m, m2, held, prevExp;
    // R1: reset state
    #(CLK_PERIOD*2 + 1);
    check("R1 valid in reset", {127'd0, valid}, 128'd0);
    check("R1 result in reset", result, 128'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", {127'd0, valid}, 128'd0);
    check("R1 result after release", result, 128'd0);

    // R3/R4: zero state and single-lane patterns
    runOp("R3 zero", '0, '0, '0);
    for (int lane = 0; lane < 4; lane++) begin
      runOp("R4 abef lane", 128'h1 << (lane*32 + lane*7), '0, '0);
      runOp("R4 cdgh lane", '0, 128'h1 << (lane*32 + lane*5), '0);
    end
    runOp("R5 msg lane0", '0, '0, 128'h0000_0000_0000_0000_0000_0000_8000_0001);
    runOp("R5 msg lane1", '0, '0, 128'h0000_0000_0000_0000_8000_0001_0000_0000);

    // R7: wrap-around with all-ones
    runOp("R7 all ones", '1, '1, {64'd0, 64'hFFFF_FFFF_FFFF_FFFF});

    // R3 sweep
    for (int i = 0; i < 64; i++) begin
      randWide(ab); randWide(cd); randWide(m);
      runOp("R3 sweep", ab, cd, m);
    end

    // R5: upper message bits ignored
    randWide(ab); randWide(cd); randWide(m);
    runOp("R5 base", ab, cd, {64'd0, m[63:0]});
    randWide(m2);
    runOp("R5 upper set", ab, cd, {m2[127:64], m[63:0]});
    check("R5 upper ignored", result, model(ab, cd, {64'd0, m[63:0]}));

    // R6: hold without start
    held = result;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      randWide(opAbef); randWide(opCdgh); randWide(opMsg);
    end
    @(negedge clk);
    check("R6 hold result", result, held);
    check("R6 no valid", {127'd0, valid}, 128'd0);

    // R8: back-to-back starts
    prevExp = '0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check("R8 valid streak", {127'd0, valid}, 128'd1);
        check("R8 streak result", result, prevExp);
      end
      randWide(ab); randWide(cd); randWide(m);
      opAbef = ab; opCdgh = cd; opMsg = m; start = 1'b1;
      prevExp = model(ab, cd, m);
    end
    @(negedge clk);
    start = 1'b0;
    check("R8 last valid", {127'd0, valid}, 128'd1);
    check("R8 last result", result, prevExp);
    @(negedge clk);
    check("R2 valid drops", {127'd0, valid}, 128'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule